// File: doc/BRIEF.md
# Conflicting PC Tag Recorder

This block holds the transactional metadata of a small direct-mapped L1 tag array used by a hardware transactional memory. Each line carries a speculative-read flag, a speculative-write flag and a 12-bit tag that records the low bits of the instruction address which first brought the line into the current transaction. Data storage and the coherence protocol itself sit elsewhere. This block only tracks which lines are speculative and where they were first touched.

Remote coherence requests are checked against the speculative lines. A clash is resolved eagerly in favour of the requester, so the local transaction aborts. The block then emits a one-cycle pulse together with a 64-bit abort record. The record names the data address of the request and the PC tag of the line, which is the first-access PC and not the PC in flight at abort time. A runtime can use this pair to work out which earlier access ought to have been serialised.

Top module: `pc_tag_recorder`

## Requirements
- R1: After reset, `in_tx`, `abort_valid` and `abort_record` are all 0.
- R2: `tx_begin` while idle raises `in_tx` on the next cycle. `tx_commit`, `tx_abort` or a conflict while in a transaction lowers it on the next cycle. A begin in the same cycle as a clear leaves `in_tx` low.
- R3: Local accesses and remote requests made while no transaction is open have no effect. A later transaction sees no speculative lines from them.
- R4: While in a transaction, a remote write (`rmt_write`=1) to a line whose read or write flag is set is a conflict. One cycle later `abort_valid` pulses and `in_tx` is 0.
- R5: A remote read (`rmt_write`=0) conflicts only with a line whose write flag is set. A remote read of a line that has only been read locally does not abort.
- R6: `abort_record` = {pc_tag[11:0], rmt_addr[51:0]}, with the PC tag in bits 63:52. The tag is `acc_pc` of the access that first made the line speculative. Later accesses to the same line in the same transaction do not change it.
- R7: Matching uses 64-byte lines, so `rmt_addr[5:0]` is ignored. The line address `rmt_addr[51:6]` must equal the stored line address: index bits [9:6] for the default 16 lines and the tag above them.
- R8: Commit and software abort clear every read and write flag in one cycle and produce no `abort_valid` pulse. A remote write afterwards does not conflict.
- R9: The PC tag is never cleared. It is rewritten when a line becomes speculative again in a new transaction.
- R10: A local access whose index holds a different line that is already speculative is dropped. That line address then cannot cause a conflict.
- R11: A conflict takes priority over a local access and a commit in the same cycle. The access is dropped and the abort is reported.
- R12: `abort_valid` is a single-cycle pulse. `abort_record` changes only with a pulse and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Commit the open transaction |
| tx_abort | input | 1 | Software abort of the open transaction |
| ld_valid | input | 1 | Local transactional load |
| st_valid | input | 1 | Local transactional store |
| acc_line | input | 46 | Line address of the local access (data address bits 51:6) |
| acc_pc | input | 12 | Low 12 bits of the local access PC |
| rmt_valid | input | 1 | Remote coherence request |
| rmt_write | input | 1 | 1 = remote write/invalidate, 0 = remote read |
| rmt_addr | input | 52 | Remote request data address |
| in_tx | output | 1 | Transaction open |
| abort_valid | output | 1 | Contention abort pulse |
| abort_record | output | 64 | {pc_tag, conflicting address} |

## Verification
The main conflict function is tried with each pairing of remote kind (read, write) against local flag state (read-only, written, untouched). This separates the asymmetric read/write rule from plain line-match detection. Address patterns vary the byte offset, the index and the tag bits independently. This shows that matching is per line and uses the full line address. Repeated accesses from different PCs, and fresh transactions on an old line, tell a first-access tag apart from a last-access or stale tag. Same-cycle collisions of conflict with commit, begin or a local access fix the priority order.

// File: rtl/pc_tag_recorder.sv
module pc_tag_recorder #(
  parameter int LINES  = 16,
  parameter int ADDR_W = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              tx_commit,
  input  logic              tx_abort,
  input  logic              ld_valid,
  input  logic              st_valid,
  input  logic [ADDR_W-7:0] acc_line,
  input  logic [11:0]       acc_pc,
  input  logic              rmt_valid,
  input  logic              rmt_write,
  input  logic [ADDR_W-1:0] rmt_addr,
  output logic              in_tx,
  output logic              abort_valid,
  output logic [ADDR_W+11:0] abort_record
);
  localparam int OFF_W = 6;
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = LA_W - IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [11:0]      pc_q  [LINES];
  logic [LINES-1:0] rd_q, wr_q;

  logic [LA_W-1:0]  r_line;
  logic [IDX_W-1:0] r_idx, l_idx;
  logic [TAG_W-1:0] r_tag, l_tag;
  logic             r_hit, conflict, clear, l_spec, l_go, l_ok, l_new;

  assign r_line   = rmt_addr[ADDR_W-1:OFF_W];
  assign r_idx    = r_line[IDX_W-1:0];
  assign r_tag    = r_line[LA_W-1:IDX_W];
  assign r_hit    = rmt_valid && in_tx && (tag_q[r_idx] == r_tag) && (rd_q[r_idx] || wr_q[r_idx]);
  assign conflict = r_hit && (rmt_write || wr_q[r_idx]);
  assign clear    = conflict || (in_tx && (tx_commit || tx_abort));

  assign l_idx  = acc_line[IDX_W-1:0];
  assign l_tag  = acc_line[LA_W-1:IDX_W];
  assign l_spec = rd_q[l_idx] || wr_q[l_idx];
  assign l_go   = in_tx && (ld_valid || st_valid) && !clear;
  assign l_new  = l_go && !l_spec;
  assign l_ok   = l_go && (!l_spec || tag_q[l_idx] == l_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_tx <= 1'b0;
      rd_q  <= '0;
      wr_q  <= '0;
    end else if (clear) begin
      in_tx <= 1'b0;
      rd_q  <= '0;
      wr_q  <= '0;
    end else begin
      if (tx_begin) in_tx <= 1'b1;
      if (l_ok) begin
        rd_q[l_idx] <= rd_q[l_idx] | ld_valid;
        wr_q[l_idx] <= wr_q[l_idx] | st_valid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (l_new) begin
      tag_q[l_idx] <= l_tag;
      pc_q[l_idx]  <= acc_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_valid  <= 1'b0;
      abort_record <= '0;
    end else begin
      abort_valid <= conflict;
      if (conflict) abort_record <= {pc_q[r_idx], rmt_addr};
    end
  end
endmodule

module pc_tag_recorder_chk #(
  parameter int ADDR_W = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_begin,
  input logic              rmt_valid,
  input logic              in_tx,
  input logic              abort_valid,
  input logic [ADDR_W+11:0] abort_record
);
  assert_begin_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_tx) |-> $past(tx_begin));
  assert_abort_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> !in_tx);
  assert_abort_from_remote_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> $past(rmt_valid));
  assert_idle_no_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tx |=> !abort_valid);
  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |=> !abort_valid);
  assert_record_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_valid |-> $stable(abort_record));
endmodule

bind pc_tag_recorder pc_tag_recorder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .rmt_valid(rmt_valid),
  .in_tx(in_tx), .abort_valid(abort_valid), .abort_record(abort_record));

// File: tb/pc_tag_recorder_bench.sv
module pc_tag_recorder_bench;
  logic clk = 0, rst_n = 0;
  logic tx_begin = 0, tx_commit = 0, tx_abort = 0, ld_valid = 0, st_valid = 0;
  logic [45:0] acc_line = '0;
  logic [11:0] acc_pc = '0;
  logic rmt_valid = 0, rmt_write = 0;
  logic [51:0] rmt_addr = '0;
  logic in_tx, abort_valid;
  logic [63:0] abort_record;

  always #4 clk = ~clk;

  pc_tag_recorder u_pc_tag_recorder (.*);

  int vectors = 0, miscompares = 0;
  string cur = "R1";
  bit started = 0, done = 0;

  bit        m_in, m_av;
  bit [63:0] m_rec;
  bit [1:0]  m_st [bit [45:0]];
  bit [11:0] m_pc [bit [45:0]];

  always @(posedge clk) begin
    bit [45:0] rl, ll;
    bit conf, clr, coll;
    started = 1;
    if (!rst_n) begin
      m_in = 0; m_av = 0; m_rec = 0; m_st.delete();
    end else begin
      rl   = rmt_addr[51:6];
      conf = m_in && rmt_valid && m_st.exists(rl) && (rmt_write || m_st[rl][1]);
      clr  = conf || (m_in && (tx_commit || tx_abort));
      m_av = conf;
      if (conf) m_rec = {m_pc[rl], rmt_addr};
      if (clr) begin
        m_st.delete(); m_in = 0;
      end else begin
        if (m_in && (ld_valid || st_valid)) begin
          ll = acc_line;
          if (m_st.exists(ll)) m_st[ll] = m_st[ll] | {st_valid, ld_valid};
          else begin
            coll = 0;
            foreach (m_st[k]) if (k[3:0] == ll[3:0]) coll = 1;
            if (!coll) begin m_st[ll] = {st_valid, ld_valid}; m_pc[ll] = acc_pc; end
          end
        end
        if (tx_begin) m_in = 1;
      end
    end
  end

  always @(negedge clk) if (started && !done) begin
    vectors++;
    if (in_tx !== m_in || abort_valid !== m_av || abort_record !== m_rec) begin
      miscompares++;
      $display("FAIL %s: in_tx=%0b abort_valid=%0b record=%h expected %0b %0b %h",
               cur, in_tx, abort_valid, abort_record, m_in, m_av, m_rec);
    end
  end

  task automatic idle();
    tx_begin = 0; tx_commit = 0; tx_abort = 0; ld_valid = 0; st_valid = 0;
    rmt_valid = 0; rmt_write = 0;
  endtask
  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    idle();
  endtask
  task automatic begin_tx(); tx_begin = 1; tick(); endtask
  task automatic load(bit [51:0] a, bit [11:0] pc);
    ld_valid = 1; acc_line = a[51:6]; acc_pc = pc; tick();
  endtask
  task automatic store(bit [51:0] a, bit [11:0] pc);
    st_valid = 1; acc_line = a[51:6]; acc_pc = pc; tick();
  endtask
  task automatic remote(bit w, bit [51:0] a);
    rmt_valid = 1; rmt_write = w; rmt_addr = a; tick(2);
  endtask

  localparam bit [51:0] A = 52'h0_1234_5640;
  localparam bit [51:0] B = 52'h0_00AB_CD80;
  localparam bit [51:0] E = 52'h0_0777_0140;

  initial begin
    idle();
    tick(3);
    rst_n = 1;
    cur = "R1"; tick(2);
    cur = "R3"; load(A, 12'h111); store(A, 12'h112); remote(1, A);
    begin_tx(); remote(1, A);
    cur = "R2"; tx_commit = 1; tick(2);
    cur = "R6"; begin_tx(); load(A, 12'h123); load(A, 12'h456); store(A, 12'h789);
    cur = "R5"; tx_commit = 1; tick();
    begin_tx(); load(A, 12'h321); remote(0, A + 52'h8);
    cur = "R7"; remote(1, A + 52'h40); remote(1, A + 52'h400);
    cur = "R4"; remote(1, A + 52'h3F); tick(2);
    cur = "R5"; begin_tx(); store(B, 12'hABC); remote(0, B + 52'h40); remote(0, B ^ 52'h8000);
    remote(0, B + 52'h11); tick();
    cur = "R8"; begin_tx(); load(A, 12'h0AA); tx_commit = 1; tick(); remote(1, A);
    begin_tx(); store(B, 12'h0BB); tx_abort = 1; tick(); remote(1, B); tx_commit = 1; tick();
    cur = "R9"; begin_tx(); load(A, 12'hDEF); remote(1, A); tick();
    cur = "R10"; begin_tx(); load(E, 12'h0E1); load(E + 52'h400, 12'h0F1);
    remote(1, E + 52'h400); remote(1, E); tick();
    cur = "R11"; begin_tx(); load(B, 12'h1B1);
    tx_commit = 1; rmt_valid = 1; rmt_write = 1; rmt_addr = B; tick(2);
    begin_tx(); load(A, 12'h2A2);
    st_valid = 1; acc_line = E[51:6]; acc_pc = 12'h2E2; rmt_valid = 1; rmt_write = 1; rmt_addr = A; tick(2);
    cur = "R2"; begin_tx(); store(E, 12'h3E3);
    tx_begin = 1; rmt_valid = 1; rmt_write = 0; rmt_addr = E; tick(2);
    cur = "R11"; begin_tx(); remote(1, E); tx_abort = 1; tick();
    cur = "R12"; begin_tx(); store(A, 12'h4A4); remote(0, A + 52'h1); tick(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule